// File: doc/BRIEF.md
# Bus-Snooping Page Mapper

This block sits next to an 8-bit processor and listens to its address bus, data bus and opcode-fetch strobe (SYNC). It never drives the processor. Software selects a memory page by executing a three-byte no-operation instruction, opcode 0xFC. The block picks up the low operand byte of that instruction as the new page number. Any access whose address falls in the 4 KiB window 0xA000 to 0xAFFF then has its high physical address bits replaced by that page. For example, page 0x33 places the window at physical 0x33000.

Interrupt handlers may switch pages as well, and handlers may nest. For this reason the block keeps a LIFO of page values. It pushes one entry each time an interrupt sequence begins and pops one at each return-from-interrupt. It detects an interrupt sequence without any interrupt pins. When an interrupt starts, the opcode fetched in the SYNC cycle is thrown away, so the address does not advance in the next cycle. The block compares address bit 0 across those two cycles, and it never decodes the discarded byte as an instruction.

Top module: `bus_page_mapper`

## Requirements
- R1: After reset the active page is 0, the nesting depth is 0, both stack flags are clear, and `mem_addr` equals `cpu_addr` zero-extended.
- R2: When `cpu_addr` is in 0xA000..0xAFFF, `win_hit` is 1 and `mem_addr` is {active page, `cpu_addr[11:0]`}. Otherwise `win_hit` is 0 and `mem_addr` is `cpu_addr` with zero upper bits. This is combinational within the same cycle.
- R3: A page-select is decoded when the byte on `cpu_data` in a cycle with `cpu_sync`=1 is 0xFC and the next cycle shows `cpu_addr[0]` changed. The `cpu_data` byte of that next cycle (operand low) becomes the pending page, and the operand high byte is ignored.
- R4: A pending page becomes active at the clock edge that ends the next `cpu_sync`=1 cycle. Accesses during that SYNC cycle still use the old page, and accesses from the following cycle use the new one.
- R5: A `cpu_sync`=1 cycle followed by a cycle with the same `cpu_addr[0]` is an interrupt entry. The active page is pushed, the page becomes 0, and the depth rises by 1. The discarded opcode is not decoded, even when it is 0xFC or 0x40.
- R6: Opcode 0x40 in a `cpu_sync`=1 cycle, followed by a cycle in which `cpu_addr[0]` changed, is a return. It pops the top entry back into the active page and lowers the depth by 1.
- R7: Entries and returns nest in LIFO order, so each return restores the page that was active when its own entry happened.
- R8: An entry at depth DEPTH stores nothing and keeps the depth at DEPTH. It sets `stk_ovf`, which stays set until reset, and the page still becomes 0.
- R9: A return at depth 0 keeps the depth at 0, sets the page to 0 and sets `stk_unf`, which stays set until reset.
- R10: Bytes 0xFC and 0x40 on `cpu_data` in cycles with `cpu_sync`=0 change neither the page nor the depth.
- R11: A pending page commits on a SYNC cycle even when that SYNC cycle turns out to be a discarded interrupt fetch, so the entry pushes the newly committed page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock, one edge per bus cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address bus |
| cpu_data | input | 8 | Processor data bus as seen in the cycle |
| cpu_sync | input | 1 | High in opcode-fetch cycles |
| mem_addr | output | PHYS_W (20) | Physical address toward memory |
| win_hit | output | 1 | Current address lies in the banked window |
| cur_page | output | PAGE_W (8) | Active page |
| nest_depth | output | $clog2(DEPTH+1) | Number of stacked pages |
| stk_ovf | output | 1 | Sticky stack overflow flag |
| stk_unf | output | 1 | Sticky stack underflow flag |

## Verification
Two functions can fall on the same clock edge. A page-select that is still pending commits on a SYNC cycle, and that same SYNC cycle can be the discarded fetch that opens an interrupt entry one cycle later. The bench provokes this by starting an entry at the very first SYNC after a page-select. It judges the result from the handler's page (0) and from the page restored by the matching return, which must be the freshly selected one. The window mapping is also swept across the whole address space and across several pages, with the expected physical address computed arithmetically.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
   localparam logic [7:0] OPC_PAGESEL = 8'hFC;
   localparam logic [7:0] OPC_RETI    = 8'h40;

   typedef struct packed {
      logic entry;
      logic reti;
      logic sel;
   } snoop_ev_t;
endpackage

// File: rtl/bpm_snoop.sv
module bpm_snoop
   import bpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cpu_sync,
   input  logic       cpu_a0,
   input  logic [7:0] cpu_data,
   output snoop_ev_t  ev
);
   logic       sync_q;
   logic       a0_q;
   logic [7:0] op_q;
   logic       advanced;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         a0_q   <= 1'b0;
         op_q   <= 8'h00;
      end else begin
         sync_q <= cpu_sync;
         if (cpu_sync) begin
            a0_q <= cpu_a0;
            op_q <= cpu_data;
         end
      end
   end

   always_comb begin
      advanced = cpu_a0 ^ a0_q;
      ev.entry = sync_q & ~advanced;
      ev.sel   = sync_q & advanced & (op_q == OPC_PAGESEL);
      ev.reti  = sync_q & advanced & (op_q == OPC_RETI);
   end

   // R10
   nosync_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_sync |=> !(ev.entry || ev.sel || ev.reti));
endmodule

// File: rtl/bpm_stack.sv
module bpm_stack #(
   parameter int W     = 8,
   parameter int DEPTH = 16,
   parameter int DW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic          empty,
   output logic          full,
   output logic [DW-1:0] count,
   output logic          ovf,
   output logic          unf
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_idx;
   logic [AW-1:0] rd_idx;
   logic [DW-1:0] cnt_dec;

   always_comb begin
      empty   = (count == '0);
      full    = (count == DW'(DEPTH));
      cnt_dec = count - DW'(1);
      wr_idx  = count[AW-1:0];
      rd_idx  = cnt_dec[AW-1:0];
      dout    = mem[rd_idx];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         ovf   <= 1'b0;
         unf   <= 1'b0;
      end else if (push) begin
         if (full) begin
            ovf <= 1'b1;
         end else begin
            mem[wr_idx] <= din;
            count       <= count + DW'(1);
         end
      end else if (pop) begin
         if (empty) unf   <= 1'b1;
         else       count <= cnt_dec;
      end
   end

   // R8
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= DW'(DEPTH));
   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   // R9
   unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf |=> unf);
   // R7
   push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push && !full |=> count == $past(count) + DW'(1));
endmodule

// File: rtl/bus_page_mapper.sv
module bus_page_mapper
   import bpm_pkg::*;
#(
   parameter int                PAGE_W   = 8,
   parameter int                OFF_W    = 12,
   parameter logic [15:0]       WIN_BASE = 16'hA000,
   parameter int                DEPTH    = 16,
   parameter logic [PAGE_W-1:0] DEF_PAGE = '0,
   parameter int                PHYS_W   = PAGE_W + OFF_W,
   parameter int                DW       = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_data,
   input  logic              cpu_sync,
   output logic [PHYS_W-1:0] mem_addr,
   output logic              win_hit,
   output logic [PAGE_W-1:0] cur_page,
   output logic [DW-1:0]     nest_depth,
   output logic              stk_ovf,
   output logic              stk_unf
);
   if (PHYS_W != PAGE_W + OFF_W) begin : g_bad_phys
      $error("PHYS_W must equal PAGE_W + OFF_W");
   end
   if (PHYS_W < 16) begin : g_bad_narrow
      $error("physical address must cover the processor address");
   end
   if (OFF_W < 1 || OFF_W > 15) begin : g_bad_off
      $error("OFF_W out of range");
   end
   if (PAGE_W > 8) begin : g_bad_page
      $error("page comes from one operand byte");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end

   snoop_ev_t         ev;
   logic [PAGE_W-1:0] page_q;
   logic [PAGE_W-1:0] pend_q;
   logic              pend_v;
   logic [PAGE_W-1:0] stk_top;
   logic              stk_empty;
   logic              stk_full;

   bpm_snoop u_snoop (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_sync (cpu_sync),
      .cpu_a0   (cpu_addr[0]),
      .cpu_data (cpu_data),
      .ev       (ev)
   );

   bpm_stack #(.W(PAGE_W), .DEPTH(DEPTH), .DW(DW)) u_stack (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (ev.entry),
      .pop   (ev.reti),
      .din   (page_q),
      .dout  (stk_top),
      .empty (stk_empty),
      .full  (stk_full),
      .count (nest_depth),
      .ovf   (stk_ovf),
      .unf   (stk_unf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q <= DEF_PAGE;
         pend_q <= DEF_PAGE;
         pend_v <= 1'b0;
      end else begin
         if (ev.entry)
            page_q <= DEF_PAGE;
         else if (ev.reti)
            page_q <= stk_empty ? DEF_PAGE : stk_top;
         else if (cpu_sync && pend_v)
            page_q <= pend_q;

         if (ev.sel) begin
            pend_q <= cpu_data[PAGE_W-1:0];
            pend_v <= 1'b1;
         end else if (cpu_sync) begin
            pend_v <= 1'b0;
         end
      end
   end

   always_comb begin
      win_hit  = (cpu_addr[15:OFF_W] == WIN_BASE[15:OFF_W]);
      mem_addr = win_hit ? {page_q, cpu_addr[OFF_W-1:0]} : PHYS_W'(cpu_addr);
      cur_page = page_q;
   end

   // R5
   entry_page_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev.entry |=> cur_page == DEF_PAGE);
   // R4
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_sync && !ev.entry && !ev.reti |=> $stable(page_q));
   // R6
   reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev.reti && !stk_empty |=> nest_depth == $past(nest_depth) - DW'(1));
   // R8
   full_push_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev.entry && stk_full |=> stk_ovf && nest_depth == DW'(DEPTH));
endmodule

// File: tb/test_bus_page_mapper.sv
module test_bus_page_mapper;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 4;
   localparam int DW = $clog2(DEPTH + 1);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic [7:0]  cpu_data = 8'hEA;
   logic        cpu_sync = 1'b0;
   logic [19:0] mem_addr;
   logic        win_hit;
   logic [7:0]  cur_page;
   logic [DW-1:0] nest_depth;
   logic        stk_ovf;
   logic        stk_unf;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0]  m_page = 8'h00;
   logic [7:0]  m_pend = 8'h00;
   logic        m_pv = 1'b0;
   logic [7:0]  m_stk [8];
   int          m_depth = 0;
   logic        m_ovf = 1'b0;
   logic        m_unf = 1'b0;
   logic [15:0] pc = 16'h1F40;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_page_mapper #(.DEPTH(DEPTH)) i_bus_page_mapper (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .cpu_sync(cpu_sync), .mem_addr(mem_addr), .win_hit(win_hit),
      .cur_page(cur_page), .nest_depth(nest_depth), .stk_ovf(stk_ovf),
      .stk_unf(stk_unf)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [19:0] exp_map(input logic [15:0] a);
      if (a >= 16'hA000 && a <= 16'hAFFF)
         return 20'(m_page) * 20'h1000 + 20'(a - 16'hA000);
      return 20'(a);
   endfunction

   task automatic drive(input logic [15:0] a, input logic [7:0] d, input logic s);
      cpu_addr = a; cpu_data = d; cpu_sync = s;
   endtask

   task automatic tick();
      logic was_sync;
      was_sync = cpu_sync;
      @(posedge clk);
      @(negedge clk);
      if (was_sync && m_pv) begin m_page = m_pend; m_pv = 1'b0; end
   endtask

   task automatic state_chk(input string tag);
      check({tag, " page"}, 32'(cur_page), 32'(m_page));
      check({tag, " depth"}, 32'(nest_depth), 32'(m_depth));
   endtask

   task automatic probe(input logic [15:0] a, input string tag);
      drive(a, 8'hEA, 1'b0);
      #1;
      check({tag, " mem_addr"}, 32'(mem_addr), 32'(exp_map(a)));
      check({tag, " win_hit"}, 32'(win_hit), 32'(a[15:12] == 4'hA));
      tick();
   endtask

   // page-select: opcode, operand low, operand high (R3)
   task automatic page_sel(input logic [7:0] p);
      drive(pc, 8'hFC, 1'b1); tick();
      drive(pc + 16'd1, p, 1'b0); tick();
      m_pend = p; m_pv = 1'b1;
      drive(pc + 16'd2, 8'hEE, 1'b0); tick();
      pc = pc + 16'd3;
   endtask

   task automatic nop_sync();
      drive(pc, 8'hEA, 1'b1); tick();
      drive(pc + 16'd1, 8'hEA, 1'b0); tick();
      pc = pc + 16'd1;
   endtask

   task automatic int_entry(input logic [7:0] op);
      drive(pc, op, 1'b1); tick();
      drive(pc, op, 1'b0); tick();
      if (m_depth == DEPTH) m_ovf = 1'b1;
      else begin m_stk[m_depth] = m_page; m_depth++; end
      m_page = 8'h00;
      drive(16'h01FF, 8'h77, 1'b0); tick();
      drive(16'hFFFA, 8'h40, 1'b0); tick();
   endtask

   task automatic reti();
      drive(pc, 8'h40, 1'b1); tick();
      drive(pc + 16'd1, 8'h00, 1'b0); tick();
      if (m_depth == 0) begin m_unf = 1'b1; m_page = 8'h00; end
      else begin m_depth--; m_page = m_stk[m_depth]; end
      pc = pc + 16'd1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] plist [4];
      plist[0] = 8'h01; plist[1] = 8'h80; plist[2] = 8'hFF; plist[3] = 8'h5A;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #1;
      state_chk("R1");
      check("R1 ovf", 32'(stk_ovf), 0);
      check("R1 unf", 32'(stk_unf), 0);
      check("R1 mem_addr", 32'(mem_addr), 32'(cpu_addr));
      @(negedge clk);

      // R2 sweep at page 0
      for (int i = 0; i < 256; i++) probe(16'(i * 257), "R2 p0");
      probe(16'h9FFF, "R2 edge"); probe(16'hA000, "R2 edge");
      probe(16'hAFFF, "R2 edge"); probe(16'hB000, "R2 edge");

      // R3/R4 page 0x33; sync cycle still old page
      page_sel(8'h33);
      drive(16'hA010, 8'hEA, 1'b1);
      #1;
      check("R4 old page in sync cycle", 32'(mem_addr), 32'h00010);
      tick();
      drive(16'hA011, 8'hEA, 1'b0);
      #1;
      check("R4 new page after sync", 32'(mem_addr), 32'h33011);
      tick();
      state_chk("R3");
      for (int i = 0; i < 64; i++) probe(16'hA000 + 16'(i * 67), "R2 p33");

      foreach (plist[k]) begin
         page_sel(plist[k]);
         nop_sync();
         state_chk("R3 sweep");
         probe(16'hA5A5, "R2 sweep");
         probe(16'hAFFF, "R2 sweep");
      end

      // R10 opcodes outside sync cycles
      drive(pc, 8'hFC, 1'b0); tick();
      drive(pc + 16'd1, 8'h12, 1'b0); tick();
      drive(pc + 16'd2, 8'h40, 1'b0); tick();
      drive(pc + 16'd3, 8'h40, 1'b0); tick();
      nop_sync();
      state_chk("R10");

      // R5 discarded opcodes not decoded
      int_entry(8'hFC);
      nop_sync();
      state_chk("R5 discarded FC");
      int_entry(8'h40);
      nop_sync();
      state_chk("R5 discarded 40");
      reti(); state_chk("R6 pop");
      reti(); state_chk("R6 pop");
      check("R9 no unf yet", 32'(stk_unf), 0);

      // R7 nesting
      page_sel(8'h11); nop_sync();
      int_entry(8'hEA);
      page_sel(8'h22); nop_sync();
      int_entry(8'hEA);
      page_sel(8'h44); nop_sync();
      state_chk("R7 inner");
      reti(); state_chk("R7 back to 22");
      probe(16'hA123, "R7 map");
      reti(); state_chk("R7 back to 11");

      // R11 commit on discarded sync cycle
      page_sel(8'h66);
      int_entry(8'hEA);
      state_chk("R11 handler");
      reti();
      state_chk("R11 restored");
      check("R11 page value", 32'(cur_page), 32'h66);

      // R8 overflow
      for (int k = 0; k <= DEPTH; k++) begin
         page_sel(8'(8'hA1 + k)); nop_sync();
         int_entry(8'hEA);
      end
      state_chk("R8 full");
      check("R8 ovf", 32'(stk_ovf), 1);
      for (int k = 0; k < DEPTH; k++) begin
         reti(); state_chk("R8 unwind");
      end
      check("R8 ovf sticky", 32'(stk_ovf), 1);

      // R9 underflow
      page_sel(8'h9C); nop_sync();
      reti();
      state_chk("R9 underflow");
      check("R9 unf", 32'(stk_unf), 32'(m_unf));
      check("R9 ovf model", 32'(stk_ovf), 32'(m_ovf));

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule